// File: doc/BRIEF.md
# Segment Translation Unit with Cached Descriptors

This block keeps one cached descriptor for each of four segment registers and turns a segment-index plus 16-bit offset reference into a physical address. Writing a segment register through the load port fills that register's entry in a single step with the selector, a 24-bit base, a 16-bit limit and a 4-bit rights field. The translation logic is the only reader of the entries.

In real mode the address is the selector shifted left by four plus the offset, kept to 20 bits, and no check is made. In protected mode every reference is checked against the cached entry before an address is formed, including instruction fetches. A reference that fails produces a fault with a cause code and no valid address. Results are registered and appear one clock after the request.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset every entry is not present, so a protected-mode request to any segment faults with cause 1, and no valid or fault output is asserted before the first request.
- R2: A load writes only the entry named by `ld_idx`. The other three entries keep their contents.
- R3: When a load and a request name the same segment in the same cycle, the request sees the old entry. The new entry applies from the next cycle.
- R4: In real mode a request yields `pa_valid` with `pa_out` = (selector × 16 + offset) mod 2^20, upper bits zero, whatever the rights field holds.
- R5: In protected mode a request that passes all checks yields `pa_valid` with `pa_out` = (base + offset) mod 2^24.
- R6: Rights bit 0 is present. A protected request to an entry with bit 0 clear faults with cause 1, ahead of any other check.
- R7: Access kind is 0 read, 1 write, 2 fetch and 3 treated as read. The kind needs rights bit 1 (readable), bit 2 (writable) or bit 3 (executable) respectively. A missing bit faults with cause 2, ahead of the limit check.
- R8: An offset greater than the limit faults with cause 3. An offset equal to the limit passes.
- R9: `pa_valid` and `fault` are never both high. On a fault `pa_out` is zero. `fault_cause` is 0 exactly when `fault` is low.
- R10: Outputs change on the clock edge that samples the request and last one cycle. A cycle without a request leaves all outputs at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_en | input | 1 | Segment register write strobe |
| ld_idx | input | 2 | Segment register being written |
| ld_sel | input | 16 | Selector value |
| ld_base | input | 24 | Descriptor base address |
| ld_limit | input | 16 | Descriptor limit (highest legal offset) |
| ld_rights | input | 4 | Rights: bit0 present, bit1 readable, bit2 writable, bit3 executable |
| req_en | input | 1 | Translation request strobe |
| req_idx | input | 2 | Segment used by the request |
| req_off | input | 16 | Offset within the segment |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| prot_mode | input | 1 | 1 protected, 0 real |
| pa_out | output | 24 | Physical address, zero unless valid |
| pa_valid | output | 1 | One-cycle pulse for a successful translation |
| fault | output | 1 | One-cycle pulse for a rejected reference |
| fault_cause | output | 2 | 0 none, 1 not present, 2 rights, 3 limit |

## Verification
The bench sweeps all sixteen rights codes against every access kind, at offsets of zero, exactly the limit, one past it and the top of the range. It also uses bases that wrap past 2^24, so a design with the wrong check order, an off-by-one limit compare or a wide adder gives the wrong cause or the wrong address. Real-mode references use selectors near the top of the range, where a design that skipped the 20-bit truncation would set high address bits. A load and a request to the same segment in one cycle show whether the design lets the new entry through too early. A second reset partway through the run shows whether stale entries survive reset.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_ABSENT = 2'd1,
    CAUSE_RIGHTS = 2'd2,
    CAUSE_LIMIT  = 2'd3
  } fault_cause_e;

  localparam int RT_PRESENT = 0;
  localparam int RT_READ    = 1;
  localparam int RT_WRITE   = 2;
  localparam int RT_EXEC    = 3;
endpackage

// File: rtl/seg_entry_store.sv
module seg_entry_store #(
  parameter int NSEG   = 4,
  parameter int IDX_W  = 2,
  parameter int SEL_W  = 16,
  parameter int BASE_W = 24,
  parameter int LIM_W  = 16,
  parameter int RT_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [SEL_W-1:0]  ld_sel,
  input  logic [BASE_W-1:0] ld_base,
  input  logic [LIM_W-1:0]  ld_limit,
  input  logic [RT_W-1:0]   ld_rights,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [SEL_W-1:0]  rd_sel,
  output logic [BASE_W-1:0] rd_base,
  output logic [LIM_W-1:0]  rd_limit,
  output logic [RT_W-1:0]   rd_rights
);
  logic [SEL_W-1:0]  sel_q   [NSEG];
  logic [BASE_W-1:0] base_q  [NSEG];
  logic [LIM_W-1:0]  lim_q   [NSEG];
  logic [RT_W-1:0]   rt_q    [NSEG];
  logic [SEL_W-1:0]  sel_d   [NSEG];
  logic [BASE_W-1:0] base_d  [NSEG];
  logic [LIM_W-1:0]  lim_d   [NSEG];
  logic [RT_W-1:0]   rt_d    [NSEG];
  logic [NSEG-1:0]   wr_hit;

  always_comb begin
    for (int i = 0; i < NSEG; i++) begin
      wr_hit[i] = ld_en && (ld_idx == IDX_W'(i));
      sel_d[i]  = wr_hit[i] ? ld_sel    : sel_q[i];
      base_d[i] = wr_hit[i] ? ld_base   : base_q[i];
      lim_d[i]  = wr_hit[i] ? ld_limit  : lim_q[i];
      rt_d[i]   = wr_hit[i] ? ld_rights : rt_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSEG; i++) begin
        sel_q[i]  <= '0;
        base_q[i] <= '0;
        lim_q[i]  <= '0;
        rt_q[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < NSEG; i++) begin
        sel_q[i]  <= sel_d[i];
        base_q[i] <= base_d[i];
        lim_q[i]  <= lim_d[i];
        rt_q[i]   <= rt_d[i];
      end
    end
  end

  // Read side: pre-update contents, so a same-cycle load is not seen.
  always_comb begin
    rd_sel    = sel_q[rd_idx];
    rd_base   = base_q[rd_idx];
    rd_limit  = lim_q[rd_idx];
    rd_rights = rt_q[rd_idx];
  end

  for (genvar g = 0; g < NSEG; g++) begin : g_ent_chk
    // R2
    present_by_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rt_q[g][0]) |-> $past(ld_en && (ld_idx == IDX_W'(g))));
    // R2
    hold_unless_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_en && (ld_idx == IDX_W'(g))) |=> $stable(base_q[g]) && $stable(lim_q[g]));
  end
endmodule

// File: rtl/seg_access_check.sv
module seg_access_check
  import seg_xlate_pkg::*;
#(
  parameter int OFS_W = 16,
  parameter int RT_W  = 4
) (
  input  logic             prot_mode,
  input  logic [1:0]       kind,
  input  logic [OFS_W-1:0] off,
  input  logic [OFS_W-1:0] limit,
  input  logic [RT_W-1:0]  rights,
  output logic             ok,
  output fault_cause_e     cause
);
  logic need_bit;

  always_comb begin
    case (acc_kind_e'(kind))
      KIND_WRITE: need_bit = rights[RT_WRITE];
      KIND_FETCH: need_bit = rights[RT_EXEC];
      default:    need_bit = rights[RT_READ];
    endcase
  end

  always_comb begin
    ok    = 1'b1;
    cause = CAUSE_NONE;
    if (prot_mode) begin
      if (!rights[RT_PRESENT]) begin
        ok    = 1'b0;
        cause = CAUSE_ABSENT;
      end else if (!need_bit) begin
        ok    = 1'b0;
        cause = CAUSE_RIGHTS;
      end else if (off > limit) begin
        ok    = 1'b0;
        cause = CAUSE_LIMIT;
      end
    end
  end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int SEL_W = 16,
  parameter int OFS_W = 16,
  parameter int PA_W  = 24,
  parameter int RA_W  = 20
) (
  input  logic             prot_mode,
  input  logic [SEL_W-1:0] sel,
  input  logic [PA_W-1:0]  base,
  input  logic [OFS_W-1:0] off,
  output logic [PA_W-1:0]  pa
);
  localparam int SHIFT_W = RA_W - SEL_W;

  logic [RA_W-1:0] seg_shifted;
  logic [RA_W-1:0] real_sum;
  logic [PA_W-1:0] prot_sum;

  always_comb begin
    seg_shifted = {sel, {SHIFT_W{1'b0}}};
    real_sum    = seg_shifted + RA_W'(off);
    prot_sum    = base + PA_W'(off);
    pa          = prot_mode ? prot_sum : PA_W'(real_sum);
  end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int NSEG  = 4,
  parameter int SEL_W = 16,
  parameter int OFS_W = 16,
  parameter int PA_W  = 24,
  parameter int RA_W  = 20,
  parameter int RT_W  = 4,
  localparam int IDX_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [SEL_W-1:0]  ld_sel,
  input  logic [PA_W-1:0]   ld_base,
  input  logic [OFS_W-1:0]  ld_limit,
  input  logic [RT_W-1:0]   ld_rights,
  input  logic              req_en,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [OFS_W-1:0]  req_off,
  input  logic [1:0]        req_kind,
  input  logic              prot_mode,
  output logic [PA_W-1:0]   pa_out,
  output logic              pa_valid,
  output logic              fault,
  output logic [1:0]        fault_cause
);
  logic [1:0] rst_sync_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  logic [SEL_W-1:0] e_sel;
  logic [PA_W-1:0]  e_base;
  logic [OFS_W-1:0] e_lim;
  logic [RT_W-1:0]  e_rt;

  seg_entry_store #(
    .NSEG(NSEG), .IDX_W(IDX_W), .SEL_W(SEL_W),
    .BASE_W(PA_W), .LIM_W(OFS_W), .RT_W(RT_W)
  ) u_store (
    .clk(clk), .rst_n(rst_s),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_sel(ld_sel), .ld_base(ld_base),
    .ld_limit(ld_limit), .ld_rights(ld_rights),
    .rd_idx(req_idx),
    .rd_sel(e_sel), .rd_base(e_base), .rd_limit(e_lim), .rd_rights(e_rt)
  );

  logic         chk_ok;
  fault_cause_e chk_cause;

  seg_access_check #(.OFS_W(OFS_W), .RT_W(RT_W)) u_check (
    .prot_mode(prot_mode), .kind(req_kind), .off(req_off),
    .limit(e_lim), .rights(e_rt), .ok(chk_ok), .cause(chk_cause)
  );

  logic [PA_W-1:0] addr_raw;

  seg_addr_gen #(.SEL_W(SEL_W), .OFS_W(OFS_W), .PA_W(PA_W), .RA_W(RA_W)) u_addr (
    .prot_mode(prot_mode), .sel(e_sel), .base(e_base), .off(req_off), .pa(addr_raw)
  );

  logic [PA_W-1:0] pa_d;
  logic            valid_d;
  logic            fault_d;
  fault_cause_e    cause_d;
  fault_cause_e    cause_q;

  always_comb begin
    valid_d = req_en && chk_ok;
    fault_d = req_en && !chk_ok;
    pa_d    = valid_d ? addr_raw : '0;
    cause_d = fault_d ? chk_cause : CAUSE_NONE;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      pa_out   <= '0;
      pa_valid <= 1'b0;
      fault    <= 1'b0;
      cause_q  <= CAUSE_NONE;
    end else begin
      pa_out   <= pa_d;
      pa_valid <= valid_d;
      fault    <= fault_d;
      cause_q  <= cause_d;
    end
  end
  assign fault_cause = cause_q;

  logic armed_q;
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  // R9
  excl_out_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !(pa_valid && fault));
  // R9
  cause_consistent_chk: assert property (@(posedge clk) disable iff (!rst_s)
    fault == (fault_cause != 2'd0));
  // R9
  fault_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_s)
    fault |-> (pa_out == '0));
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_s)
    armed_q && !$past(req_en) |-> !pa_valid && !fault);
  // R4
  real_valid_chk: assert property (@(posedge clk) disable iff (!rst_s)
    armed_q && $past(req_en && !prot_mode) |-> pa_valid && (pa_out[PA_W-1:RA_W] == '0));
endmodule

// File: tb/seg_xlate_unit_test.sv
`timescale 1ns/1ps
module seg_xlate_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_en;
  logic [1:0]  ld_idx;
  logic [15:0] ld_sel;
  logic [23:0] ld_base;
  logic [15:0] ld_limit;
  logic [3:0]  ld_rights;
  logic        req_en;
  logic [1:0]  req_idx;
  logic [15:0] req_off;
  logic [1:0]  req_kind;
  logic        prot_mode;
  logic [23:0] pa_out;
  logic        pa_valid;
  logic        fault;
  logic [1:0]  fault_cause;

  always #4 clk = ~clk;

  seg_xlate_unit uut (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_sel(ld_sel), .ld_base(ld_base),
    .ld_limit(ld_limit), .ld_rights(ld_rights),
    .req_en(req_en), .req_idx(req_idx), .req_off(req_off), .req_kind(req_kind),
    .prot_mode(prot_mode),
    .pa_out(pa_out), .pa_valid(pa_valid), .fault(fault), .fault_cause(fault_cause)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [15:0] m_sel  [4];
  logic [23:0] m_base [4];
  logic [15:0] m_lim  [4];
  logic [3:0]  m_rt   [4];

  task automatic model_clear();
    for (int i = 0; i < 4; i++) begin
      m_sel[i] = '0; m_base[i] = '0; m_lim[i] = '0; m_rt[i] = '0;
    end
  endtask

  task automatic expect_of(input int idx, input logic [15:0] off, input logic [1:0] kind,
                           input logic pm, output logic [23:0] e_pa, output logic e_v,
                           output logic e_f, output logic [1:0] e_c);
    logic [20:0] rs;
    logic [24:0] ps;
    logic need;
    e_pa = '0; e_v = 1'b0; e_f = 1'b0; e_c = 2'd0;
    need = (kind == 2'd1) ? m_rt[idx][2] : (kind == 2'd2) ? m_rt[idx][3] : m_rt[idx][1];
    if (!pm) begin
      rs = {5'b0, m_sel[idx]} * 21'd16 + {5'b0, off};
      e_pa = {4'b0, rs[19:0]};
      e_v = 1'b1;
    end else if (!m_rt[idx][0]) begin
      e_f = 1'b1; e_c = 2'd1;
    end else if (!need) begin
      e_f = 1'b1; e_c = 2'd2;
    end else if (off > m_lim[idx]) begin
      e_f = 1'b1; e_c = 2'd3;
    end else begin
      ps = {1'b0, m_base[idx]} + {9'b0, off};
      e_pa = ps[23:0];
      e_v = 1'b1;
    end
  endtask

  task automatic compare(input string tag, input logic [23:0] e_pa, input logic e_v,
                         input logic e_f, input logic [1:0] e_c);
    n_chk++;
    if (pa_out !== e_pa || pa_valid !== e_v || fault !== e_f || fault_cause !== e_c) begin
      n_bad++;
      $display("FAIL %s: got pa=%h v=%b f=%b c=%0d, expected pa=%h v=%b f=%b c=%0d",
               tag, pa_out, pa_valid, fault, fault_cause, e_pa, e_v, e_f, e_c);
    end
  endtask

  task automatic do_load(input int idx, input logic [15:0] sel, input logic [23:0] base,
                         input logic [15:0] lim, input logic [3:0] rt);
    ld_en = 1'b1; ld_idx = 2'(idx); ld_sel = sel; ld_base = base;
    ld_limit = lim; ld_rights = rt;
    @(negedge clk);
    ld_en = 1'b0;
    m_sel[idx] = sel; m_base[idx] = base; m_lim[idx] = lim; m_rt[idx] = rt;
  endtask

  task automatic do_req(input string tag, input int idx, input logic [15:0] off,
                        input logic [1:0] kind, input logic pm);
    logic [23:0] e_pa; logic e_v, e_f; logic [1:0] e_c;
    expect_of(idx, off, kind, pm, e_pa, e_v, e_f, e_c);
    req_en = 1'b1; req_idx = 2'(idx); req_off = off; req_kind = kind; prot_mode = pm;
    @(negedge clk);
    req_en = 1'b0;
    compare(tag, e_pa, e_v, e_f, e_c);
  endtask

  task automatic idle_check(input string tag);
    @(negedge clk);
    compare(tag, 24'h0, 1'b0, 1'b0, 2'd0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_clear();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got no finish, expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    ld_en = 0; ld_idx = 0; ld_sel = 0; ld_base = 0; ld_limit = 0; ld_rights = 0;
    req_en = 0; req_idx = 0; req_off = 0; req_kind = 0; prot_mode = 1;
    model_clear();
    @(negedge clk);
    do_reset();

    // R1: reset state
    idle_check("R1 idle after reset");
    for (int i = 0; i < 4; i++) do_req("R1 absent after reset", i, 16'h0, 2'd0, 1'b1);
    idle_check("R10 one-cycle pulse");

    // R2: independent entries
    for (int i = 0; i < 4; i++)
      do_load(i, 16'h1000 * 16'(i + 1), 24'h100000 * 24'(i + 1), 16'h0040 * 16'(i + 1), 4'hF);
    for (int i = 0; i < 4; i++) do_req("R2 entry independence", i, 16'h0030, 2'd0, 1'b1);
    do_load(2, 16'h0, 24'h0, 16'h0, 4'h0);
    for (int i = 0; i < 4; i++) do_req("R2 neighbours kept", i, 16'h0030, 2'd1, 1'b1);

    // R6 R7 R8 R5: full rights sweep with boundary offsets
    for (int rt = 0; rt < 16; rt++) begin
      logic [15:0] lim;
      logic [23:0] base;
      int idx;
      idx  = rt % 4;
      lim  = 16'h0100 + 16'(rt) * 16'h0111;
      base = (rt % 3 == 0) ? 24'hFFFF80 : 24'h00F000 * 24'(rt) + 24'h000ABC;
      do_load(idx, 16'(rt) * 16'h0F01, base, lim, 4'(rt));
      for (int k = 0; k < 4; k++) begin
        do_req("R6/R7/R5 offset zero", idx, 16'h0, 2'(k), 1'b1);
        do_req("R8 offset at limit", idx, lim, 2'(k), 1'b1);
        do_req("R8 offset past limit", idx, lim + 16'h1, 2'(k), 1'b1);
        do_req("R8 top offset", idx, 16'hFFFF, 2'(k), 1'b1);
      end
    end
    idle_check("R10 quiet after sweep");

    // R4: real mode, rights ignored, 20-bit wrap
    for (int i = 0; i < 4; i++) begin
      logic [15:0] s;
      s = (i == 0) ? 16'hFFFF : (i == 1) ? 16'h1234 : (i == 2) ? 16'h0000 : 16'hF000;
      do_load(i, s, 24'hABCDEF, 16'h0000, 4'h0);
      do_req("R4 real offset zero", i, 16'h0000, 2'd1, 1'b0);
      do_req("R4 real top offset", i, 16'hFFFF, 2'd2, 1'b0);
      do_req("R4 real mid offset", i, 16'h0010, 2'd0, 1'b0);
    end

    // R3: same-cycle load and request see the old entry
    do_load(1, 16'h0, 24'h200000, 16'h00FF, 4'h3);
    begin
      logic [23:0] e_pa; logic e_v, e_f; logic [1:0] e_c;
      expect_of(1, 16'h0010, 2'd0, 1'b1, e_pa, e_v, e_f, e_c);
      ld_en = 1'b1; ld_idx = 2'd1; ld_sel = 16'h0; ld_base = 24'h300000;
      ld_limit = 16'h00FF; ld_rights = 4'h0;
      req_en = 1'b1; req_idx = 2'd1; req_off = 16'h0010; req_kind = 2'd0; prot_mode = 1'b1;
      @(negedge clk);
      ld_en = 1'b0; req_en = 1'b0;
      compare("R3 old entry same cycle", e_pa, e_v, e_f, e_c);
      m_base[1] = 24'h300000; m_rt[1] = 4'h0;
    end
    do_req("R3 new entry next cycle", 1, 16'h0010, 2'd0, 1'b1);

    // R1: reset clears loaded entries
    do_load(0, 16'h0, 24'h000100, 16'hFFFF, 4'hF);
    do_reset();
    do_req("R1 absent after second reset", 0, 16'h0, 2'd0, 1'b1);
    idle_check("R9 quiet after fault");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule